// File: doc/BRIEF.md
# Power Mode and Wake Sequencer

This block steers a battery monitor through four operating states: normal, sleep, shutdown and battery-removed. A free-running base tick is divided down to produce a measurement request pulse. In normal mode the request comes once per second, which is a fixed number of ticks. In sleep mode the request comes at a programmable number of ticks. Between requests the rest of the monitor can stay in a reduced-power condition. Firmware asks for sleep or shutdown through plain request pins.

A sleeping monitor wakes when either of two things happens:
- a converted current sample, of either sign, has a magnitude above a threshold picked by a three-bit code;
- a fault is flagged.

Shutdown stops all activity until the pack voltage reaches the startup level.

An active-low presence input is looked at only on measurement ticks. When it reads high, the block enters the removed state and forces the charge, discharge and precharge switch enables off. A configuration bit makes the block ignore the presence input altogether. After reset, and after any return from shutdown or removal, the switch enables stay off until a measurement cycle is reported complete.

The current samples arrive as a valid/ready stream. A sample is taken on a cycle where valid and ready are both high. Ready is low only in shutdown. The producer is not asked to hold a refused sample; it may drop it and send a newer one later.

Top module: `pwr_mode_seq`

## Requirements
- R1: A synchronous active-high reset sets the state to normal (state code 2'b00), clears the request pulse and holds all three switch enables low until the first meas_done_i pulse.
- R2: In normal state, meas_req_o is high for exactly one cycle, in the cycle after every NORM_TICKS-th tick_i pulse. Ticks are counted from the last state change or from reset.
- R3: In sleep state (code 2'b01), the request pulse comes after every sleep_intv_i-th tick instead. A value of 0 is treated as 1.
- R4: In normal state, sleep_req_i moves the block to sleep on the next clock edge, unless fault_i is high in that cycle.
- R5: In sleep state, an accepted current sample whose magnitude is strictly greater than the selected threshold moves the block to normal on the next clock edge. This holds for both positive and negative samples.
- R6: The threshold code {cfg_wake_hi_i, cfg_range_i} selects the threshold as follows:
  - 0/01 selects TH_L0;
  - 1/01 and 0/10 select TH_L1;
  - 0/11 and 1/10 select TH_L2;
  - 1/11 selects TH_L3;
  - any code with cfg_range_i = 00 selects TH_L0.
- R7: In sleep state, fault_i high moves the block to normal on the next clock edge.
- R8: In normal state, shdn_req_i moves the block to shutdown (code 2'b10). Shutdown behaves as follows:
  - no request pulses are issued and all switch enables are low;
  - the block leaves shutdown only when pack_ok_i is high, and then goes to normal;
  - on that return the enables stay low until meas_done_i.
- R9: pres_n_i is sampled only in cycles with tick_i high. A high sample taken in normal or sleep moves the block to removed (code 2'b11), with all enables low. A low sample taken in removed returns the block to normal, with the enables low until meas_done_i.
- R10: With cfg_norem_i high, a high pres_n_i never causes removal. In that case the removed state returns to normal on the next tick.
- R11: In normal or sleep state, once armed by meas_done_i, the switch enables follow sw_req_i: bit 0 drives chg_en_o, bit 1 drives dsg_en_o and bit 2 drives pre_en_o.
- R12: cur_ready_o is low only in shutdown. A sample with cur_valid_i low has no effect on the state.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| tick_i | input | 1 | Base measurement tick, one cycle wide |
| cur_valid_i | input | 1 | Current sample valid |
| cur_ready_o | output | 1 | Current sample ready (low in shutdown) |
| cur_i | input | CUR_W | Signed current sample in sense LSBs |
| pres_n_i | input | 1 | Active-low pack presence |
| pack_ok_i | input | 1 | Pack voltage at startup level |
| fault_i | input | 1 | Failure flag |
| meas_done_i | input | 1 | Measurement cycle completed |
| sleep_req_i | input | 1 | Request to enter sleep |
| shdn_req_i | input | 1 | Request to enter shutdown |
| cfg_wake_hi_i | input | 1 | Wake threshold code, upper bit |
| cfg_range_i | input | 2 | Wake threshold code, sense range bits |
| cfg_norem_i | input | 1 | Ignore presence input |
| sleep_intv_i | input | INTV_W | Sleep request interval in ticks |
| sw_req_i | input | 3 | Requested switch enables {pre, dsg, chg} |
| meas_req_o | output | 1 | Measurement request pulse |
| state_o | output | 2 | Current state code |
| chg_en_o | output | 1 | Charge switch enable |
| dsg_en_o | output | 1 | Discharge switch enable |
| pre_en_o | output | 1 | Precharge switch enable |

## Verification
The bench builds the block with NORM_TICKS = 4 and INTV_W = 6, keeping the default 16-bit current width and thresholds of 4, 9, 18 and 36 LSBs. The short normal period lets a few ticks reach the request boundary, both in normal mode and after a sleep interval. The 16-bit width puts the most negative sample within reach, so the magnitude path is exercised at that extreme. The thresholds allow each comparison to be probed at exactly the threshold and one LSB above it, for both signs.

// File: rtl/pwr_mode_pkg.sv
package pwr_mode_pkg;

  typedef enum logic [1:0] {
    PM_NORMAL   = 2'b00,
    PM_SLEEP    = 2'b01,
    PM_SHUTDOWN = 2'b10,
    PM_REMOVED  = 2'b11
  } pm_state_e;

  localparam int unsigned PM_NUM_SW     = 3;
  localparam int unsigned PM_NUM_LEVELS = 4;

endpackage

// File: rtl/pm_wake_cmp.sv
module pm_wake_cmp #(
  parameter int unsigned CUR_W = 16,
  parameter int unsigned TH_L0 = 4,
  parameter int unsigned TH_L1 = 9,
  parameter int unsigned TH_L2 = 18,
  parameter int unsigned TH_L3 = 36
) (
  input  logic                    wake_hi_i,
  input  logic [1:0]              range_i,
  input  logic                    take_i,
  input  logic signed [CUR_W-1:0] cur_i,
  output logic                    wake_o
);

  import pwr_mode_pkg::*;

  localparam int unsigned MAG_W = CUR_W + 1;

  function automatic logic [MAG_W-1:0] th_of(input int unsigned idx);
    case (idx)
      0:       return MAG_W'(TH_L0);
      1:       return MAG_W'(TH_L1);
      2:       return MAG_W'(TH_L2);
      default: return MAG_W'(TH_L3);
    endcase
  endfunction

  logic signed [MAG_W-1:0] ext;
  logic [MAG_W-1:0]        mag;
  logic [1:0]              level;
  logic [PM_NUM_LEVELS-1:0] above;

  assign ext = MAG_W'(cur_i);
  assign mag = ext[MAG_W-1] ? MAG_W'(-ext) : MAG_W'(ext);

  always_comb begin
    case ({wake_hi_i, range_i})
      3'b0_01: level = 2'd0;
      3'b1_01: level = 2'd1;
      3'b0_10: level = 2'd1;
      3'b0_11: level = 2'd2;
      3'b1_10: level = 2'd2;
      3'b1_11: level = 2'd3;
      default: level = 2'd0;
    endcase
  end

  for (genvar g = 0; g < PM_NUM_LEVELS; g++) begin : g_lvl
    assign above[g] = mag > th_of(g);
  end

  assign wake_o = take_i & above[level];

endmodule

// File: rtl/pm_interval.sv
module pm_interval #(
  parameter int unsigned INTV_W     = 8,
  parameter int unsigned NORM_TICKS = 8
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              tick_i,
  input  logic              restart_i,
  input  logic              sleep_i,
  input  logic              run_i,
  input  logic [INTV_W-1:0] intv_i,
  output logic              req_o
);

  localparam int unsigned NT_W  = $clog2(NORM_TICKS + 1);
  localparam int unsigned CNT_W = (INTV_W > NT_W) ? INTV_W : NT_W;

  logic [CNT_W-1:0] cnt_q;
  logic [CNT_W-1:0] period;
  logic             hit;
  logic             req_q;

  always_comb begin
    if (sleep_i) begin
      period = (intv_i == '0) ? CNT_W'(1) : CNT_W'(intv_i);
    end else begin
      period = CNT_W'(NORM_TICKS);
    end
  end

  assign hit = cnt_q >= (period - CNT_W'(1));

  always_ff @(posedge clk) begin
    if (rst || restart_i) begin
      cnt_q <= '0;
    end else if (tick_i && run_i) begin
      cnt_q <= hit ? '0 : cnt_q + CNT_W'(1);
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      req_q <= 1'b0;
    end else begin
      req_q <= tick_i & run_i & hit & ~restart_i;
    end
  end

  assign req_o = req_q;

  AST_REQ_ON_TICK: assert property (@(posedge clk) disable iff (rst)
    req_q |-> $past(tick_i)); // R2

endmodule

// File: rtl/pm_fsm.sv
module pm_fsm
  import pwr_mode_pkg::*;
(
  input  logic      clk,
  input  logic      rst,
  input  logic      tick_i,
  input  logic      pres_n_i,
  input  logic      norem_i,
  input  logic      pack_ok_i,
  input  logic      fault_i,
  input  logic      sleep_req_i,
  input  logic      shdn_req_i,
  input  logic      wake_i,
  input  logic      meas_done_i,
  output pm_state_e state_q,
  output pm_state_e state_d,
  output logic      armed_o
);

  logic gone;
  logic armed_q;
  logic quiet_q;
  logic quiet_d;

  assign gone = ~norem_i & pres_n_i;

  always_comb begin
    state_d = state_q;
    case (state_q)
      PM_NORMAL: begin
        if (tick_i && gone)              state_d = PM_REMOVED;
        else if (shdn_req_i)             state_d = PM_SHUTDOWN;
        else if (sleep_req_i && !fault_i) state_d = PM_SLEEP;
      end
      PM_SLEEP: begin
        if (tick_i && gone)          state_d = PM_REMOVED;
        else if (wake_i || fault_i)  state_d = PM_NORMAL;
      end
      PM_SHUTDOWN: begin
        if (pack_ok_i) state_d = PM_NORMAL;
      end
      default: begin
        if (tick_i && !gone) state_d = PM_NORMAL;
      end
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst) state_q <= PM_NORMAL;
    else     state_q <= state_d;
  end

  assign quiet_q = (state_q == PM_SHUTDOWN) || (state_q == PM_REMOVED);
  assign quiet_d = (state_d == PM_SHUTDOWN) || (state_d == PM_REMOVED);

  always_ff @(posedge clk) begin
    if (rst || quiet_q || quiet_d) armed_q <= 1'b0;
    else if (meas_done_i)          armed_q <= 1'b1;
  end

  assign armed_o = armed_q;

  AST_WAKE_LEAVES_SLEEP: assert property (@(posedge clk) disable iff (rst)
    (state_q == PM_SLEEP && (wake_i || fault_i)) |=> state_q != PM_SLEEP); // R5

  AST_SHDN_HOLD: assert property (@(posedge clk) disable iff (rst)
    (state_q == PM_SHUTDOWN && !pack_ok_i) |=> state_q == PM_SHUTDOWN); // R8

  AST_REMOVE_ON_TICK: assert property (@(posedge clk) disable iff (rst)
    (state_q == PM_REMOVED && $past(state_q) != PM_REMOVED) |-> $past(tick_i)); // R9

  AST_NOREM_KEEPS: assert property (@(posedge clk) disable iff (rst)
    (norem_i && state_q != PM_REMOVED) |=> state_q != PM_REMOVED); // R10

endmodule

// File: rtl/pwr_mode_seq.sv
module pwr_mode_seq
  import pwr_mode_pkg::*;
#(
  parameter int unsigned CUR_W      = 16,
  parameter int unsigned INTV_W     = 8,
  parameter int unsigned NORM_TICKS = 8,
  parameter int unsigned TH_L0      = 4,
  parameter int unsigned TH_L1      = 9,
  parameter int unsigned TH_L2      = 18,
  parameter int unsigned TH_L3      = 36
) (
  input  logic                    clk,
  input  logic                    rst,
  input  logic                    tick_i,
  input  logic                    cur_valid_i,
  output logic                    cur_ready_o,
  input  logic signed [CUR_W-1:0] cur_i,
  input  logic                    pres_n_i,
  input  logic                    pack_ok_i,
  input  logic                    fault_i,
  input  logic                    meas_done_i,
  input  logic                    sleep_req_i,
  input  logic                    shdn_req_i,
  input  logic                    cfg_wake_hi_i,
  input  logic [1:0]              cfg_range_i,
  input  logic                    cfg_norem_i,
  input  logic [INTV_W-1:0]       sleep_intv_i,
  input  logic [PM_NUM_SW-1:0]    sw_req_i,
  output logic                    meas_req_o,
  output logic [1:0]              state_o,
  output logic                    chg_en_o,
  output logic                    dsg_en_o,
  output logic                    pre_en_o
);

  pm_state_e state_q;
  pm_state_e state_d;
  logic      armed;
  logic      wake;
  logic      take;
  logic      live;
  logic      ready;
  logic [PM_NUM_SW-1:0] sw_en;

  assign ready = (state_q != PM_SHUTDOWN);
  assign take  = cur_valid_i & ready;

  pm_wake_cmp #(
    .CUR_W (CUR_W),
    .TH_L0 (TH_L0),
    .TH_L1 (TH_L1),
    .TH_L2 (TH_L2),
    .TH_L3 (TH_L3)
  ) i_cmp (
    .wake_hi_i (cfg_wake_hi_i),
    .range_i   (cfg_range_i),
    .take_i    (take),
    .cur_i     (cur_i),
    .wake_o    (wake)
  );

  pm_fsm i_fsm (
    .clk         (clk),
    .rst         (rst),
    .tick_i      (tick_i),
    .pres_n_i    (pres_n_i),
    .norem_i     (cfg_norem_i),
    .pack_ok_i   (pack_ok_i),
    .fault_i     (fault_i),
    .sleep_req_i (sleep_req_i),
    .shdn_req_i  (shdn_req_i),
    .wake_i      (wake),
    .meas_done_i (meas_done_i),
    .state_q     (state_q),
    .state_d     (state_d),
    .armed_o     (armed)
  );

  pm_interval #(
    .INTV_W     (INTV_W),
    .NORM_TICKS (NORM_TICKS)
  ) i_intv (
    .clk       (clk),
    .rst       (rst),
    .tick_i    (tick_i),
    .restart_i (state_d != state_q),
    .sleep_i   (state_q == PM_SLEEP),
    .run_i     (state_d != PM_SHUTDOWN),
    .intv_i    (sleep_intv_i),
    .req_o     (meas_req_o)
  );

  assign live = (state_q == PM_NORMAL) || (state_q == PM_SLEEP);

  for (genvar g = 0; g < PM_NUM_SW; g++) begin : g_sw
    assign sw_en[g] = live & armed & sw_req_i[g];
  end

  assign chg_en_o    = sw_en[0];
  assign dsg_en_o    = sw_en[1];
  assign pre_en_o    = sw_en[2];
  assign state_o     = state_q;
  assign cur_ready_o = ready;

  AST_SHDN_NO_REQ: assert property (@(posedge clk) disable iff (rst)
    (state_q == PM_SHUTDOWN) |-> !meas_req_o); // R8

  AST_RETURN_UNARMED: assert property (@(posedge clk) disable iff (rst)
    (state_q == PM_NORMAL && $past(state_q) == PM_SHUTDOWN)
      |-> (!chg_en_o && !dsg_en_o && !pre_en_o)); // R8

  AST_REMOVED_OFF: assert property (@(posedge clk) disable iff (rst)
    (state_q == PM_REMOVED) |-> $countones({chg_en_o, dsg_en_o, pre_en_o}) == 0); // R9

endmodule

// File: tb/test_pwr_mode_seq.sv
module test_pwr_mode_seq;

  logic              clk = 1'b0;
  logic              rst = 1'b1;
  logic              tick = 1'b0;
  logic              cur_valid = 1'b0;
  logic              cur_ready;
  logic signed [15:0] cur = '0;
  logic              pres_n = 1'b0;
  logic              pack_ok = 1'b0;
  logic              fault = 1'b0;
  logic              meas_done = 1'b0;
  logic              sleep_req = 1'b0;
  logic              shdn_req = 1'b0;
  logic              wake_hi = 1'b0;
  logic [1:0]        range_c = 2'b01;
  logic              norem = 1'b0;
  logic [5:0]        intv = 6'd3;
  logic [2:0]        sw_req = 3'b111;
  logic              meas_req;
  logic [1:0]        state;
  logic              chg_en, dsg_en, pre_en;

  int checks = 0;
  int failures = 0;
  bit done = 0;

  always #10 clk = ~clk;

  pwr_mode_seq #(
    .CUR_W (16), .INTV_W (6), .NORM_TICKS (4)
  ) i_pwr_mode_seq (
    .clk (clk), .rst (rst), .tick_i (tick),
    .cur_valid_i (cur_valid), .cur_ready_o (cur_ready), .cur_i (cur),
    .pres_n_i (pres_n), .pack_ok_i (pack_ok), .fault_i (fault),
    .meas_done_i (meas_done), .sleep_req_i (sleep_req), .shdn_req_i (shdn_req),
    .cfg_wake_hi_i (wake_hi), .cfg_range_i (range_c), .cfg_norem_i (norem),
    .sleep_intv_i (intv), .sw_req_i (sw_req), .meas_req_o (meas_req),
    .state_o (state), .chg_en_o (chg_en), .dsg_en_o (dsg_en), .pre_en_o (pre_en)
  );

  task automatic check(input string tag, input int got, input int exp);
    checks++;
    if (got != exp) begin
      failures++;
      $display("FAIL %s actual=%0d expected=%0d", tag, got, exp);
    end
  endtask

  task automatic step();
    @(negedge clk);
  endtask

  task automatic pulse_tick();
    tick = 1'b1;
    step();
    tick = 1'b0;
  endtask

  task automatic arm();
    meas_done = 1'b1;
    step();
    meas_done = 1'b0;
  endtask

  task automatic sample(input logic signed [15:0] v);
    cur_valid = 1'b1;
    cur = v;
    step();
    cur_valid = 1'b0;
  endtask

  task automatic go_sleep();
    sleep_req = 1'b1;
    step();
    sleep_req = 1'b0;
  endtask

  task automatic t_reset();
    rst = 1'b1;
    repeat (3) step();
    rst = 1'b0;
    step();
    check("R1 state", state, 0);
    check("R1 meas_req", meas_req, 0);
    check("R1 enables off", {pre_en, dsg_en, chg_en}, 0);
  endtask

  task automatic t_normal_interval();
    for (int k = 1; k <= 3; k++) begin
      pulse_tick();
      check("R2 no req before period", meas_req, 0);
    end
    pulse_tick();
    check("R2 req at 4th tick", meas_req, 1);
    step();
    check("R2 one cycle pulse", meas_req, 0);
    arm();
    sw_req = 3'b101;
    step();
    check("R11 enables follow request", {pre_en, dsg_en, chg_en}, 5);
    sw_req = 3'b111;
  endtask

  task automatic t_sleep();
    fault = 1'b1;
    go_sleep();
    check("R4 fault blocks sleep", state, 0);
    fault = 1'b0;
    go_sleep();
    check("R4 sleep entered", state, 1);
    check("R11 enables in sleep", {pre_en, dsg_en, chg_en}, 7);
    intv = 6'd3;
    pulse_tick();
    pulse_tick();
    check("R3 no req before sleep interval", meas_req, 0);
    pulse_tick();
    check("R3 req at sleep interval", meas_req, 1);
    intv = 6'd0;
    pulse_tick();
    check("R3 zero interval acts as one", meas_req, 1);
    intv = 6'd3;
  endtask

  task automatic t_wake();
    wake_hi = 1'b0; range_c = 2'b01;
    sample(16'sd4);
    check("R6 level0 at threshold stays", state, 1);
    sample(-16'sd5);
    check("R5 negative above threshold wakes", state, 0);
    go_sleep();
    cur_valid = 1'b0; cur = 16'sd1000;
    step();
    check("R12 invalid sample ignored", state, 1);
    wake_hi = 1'b1; range_c = 2'b11;
    sample(16'sd36);
    check("R6 level3 at threshold stays", state, 1);
    sample(16'sd37);
    check("R5 positive above threshold wakes", state, 0);
    go_sleep();
    wake_hi = 1'b0; range_c = 2'b10;
    sample(-16'sd9);
    check("R6 level1 code 0/10 stays", state, 1);
    sample(-16'sd10);
    check("R6 level1 code 0/10 wakes", state, 0);
    go_sleep();
    wake_hi = 1'b1; range_c = 2'b11;
    sample(-16'sd32768);
    check("R5 most negative sample wakes", state, 0);
  endtask

  task automatic t_fault_wake();
    go_sleep();
    check("R7 in sleep", state, 1);
    fault = 1'b1;
    step();
    fault = 1'b0;
    check("R7 fault wakes", state, 0);
  endtask

  task automatic t_shutdown();
    int reqs = 0;
    shdn_req = 1'b1;
    step();
    shdn_req = 1'b0;
    check("R8 shutdown entered", state, 2);
    check("R12 ready low in shutdown", cur_ready, 0);
    check("R8 enables off in shutdown", {pre_en, dsg_en, chg_en}, 0);
    for (int k = 0; k < 6; k++) begin
      pulse_tick();
      reqs += meas_req;
    end
    check("R8 no requests in shutdown", reqs, 0);
    check("R8 stays without pack voltage", state, 2);
    pack_ok = 1'b1;
    step();
    pack_ok = 1'b0;
    check("R8 exit on pack voltage", state, 0);
    check("R12 ready back", cur_ready, 1);
    check("R8 enables off until measured", {pre_en, dsg_en, chg_en}, 0);
    arm();
    check("R8 enables after measurement", {pre_en, dsg_en, chg_en}, 7);
  endtask

  task automatic t_presence();
    pres_n = 1'b1;
    repeat (3) step();
    check("R9 no change between ticks", state, 0);
    pulse_tick();
    check("R9 removed on tick", state, 3);
    check("R9 enables forced off", {pre_en, dsg_en, chg_en}, 0);
    pres_n = 1'b0;
    repeat (2) step();
    check("R9 removed held between ticks", state, 3);
    pulse_tick();
    check("R9 back to normal on tick", state, 0);
    check("R9 enables off until measured", {pre_en, dsg_en, chg_en}, 0);
    arm();
    check("R9 enables after measurement", {pre_en, dsg_en, chg_en}, 7);
  endtask

  task automatic t_norem();
    norem = 1'b1;
    pres_n = 1'b1;
    pulse_tick();
    check("R10 presence ignored", state, 0);
    check("R10 enables kept", {pre_en, dsg_en, chg_en}, 7);
    norem = 1'b0;
    pulse_tick();
    check("R10 removal once bit cleared", state, 3);
    norem = 1'b1;
    pulse_tick();
    check("R10 removed returns with bit set", state, 0);
    norem = 1'b0;
    pres_n = 1'b0;
  endtask

  initial begin
    step();
    t_reset();
    t_normal_interval();
    t_sleep();
    t_wake();
    t_fault_wake();
    t_shutdown();
    t_presence();
    t_norem();
    done = 1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      checks++;
      failures++;
      $display("FAIL watchdog actual=timeout expected=finish");
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end

endmodule